// File: doc/BRIEF.md
# Receive Packet Store with Slot Descriptors

The block holds received packets in a circular byte buffer and keeps a table of eight descriptor slots beside it. A write side delivers packet bytes one at a time, marked with start and end flags and an information byte at the end. When a packet ends and is accepted, it takes the next slot in ring order. The slot records the packet's start address, its length and its information byte.

A host reads and controls the store through a small register set. The address (4 bits) selects a register: 0 current slot, 1 valid bitmap, 2 slot select, 3 info, 4 length, 5 start, 6 head, 7 tail, 8 full status, 9 control, 10 data. Registers 3, 4 and 5 show the slot chosen by the slot select register (bits 2:0). Reading the data register returns the byte at the head pointer, and the same access moves the head forward.

The host can drop the current packet or empty the whole store without reading any bytes. When byte space or descriptor slots run out, a full interrupt is raised, and the status register shows which of the two caused it. Buffer addresses wrap modulo the buffer size. Pointers carry one extra wrap bit, so a completely full buffer can be told apart from an empty one.

Top module: `rxb_pkt_store`

## Requirements
- R1: After reset, registers 0 (current slot), 1 (valid bitmap), 6 (head), 7 (tail) and 8 (full status) all read 0x00, and full_irq is low.
- R2: A packet that is accepted sets bit n of register 1, where n is the slot it took. That slot's register 4 reads the byte count, register 3 reads the information byte given with the end marker, and register 5 reads the address of the packet's first byte. A packet whose start and end flags are on the same byte is one byte long.
- R3: Register 7 (tail) holds the address just past the last byte of the newest accepted packet, and the next packet starts at that address.
- R4: Each read of register 10 returns the next byte of the current packet in arrival order and adds one to register 6 (head).
- R5: Writing 1 to bit 1 of register 9 discards the current packet. Its valid bit clears, register 0 moves to the oldest remaining valid slot, and register 6 moves to that slot's start address.
- R6: Register 8 bit 0 is set when the buffer holds as many bytes as it has room for, or when a byte is refused for lack of space. Bit 1 is set when all eight slots are valid, or when a packet is refused for lack of a slot. Both bits are sticky until a discard or a clear-all. full_irq is high while either bit is set.
- R7: A packet that finds no free slot, or no byte space, is dropped whole. Register 7 and register 1 keep the values they had before the packet arrived.
- R8: Writing 1 to bit 0 of register 9 clears every valid bit at once.
- R9: Addresses wrap modulo the buffer size. A packet exactly as long as the buffer is accepted, and its bytes read back correctly across the wrap.
- R10: Bits 2:0 of register 0 can be written to select the current slot. Bits 7:3 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A packet byte is present this cycle |
| in_sop | input | 1 | The byte is the first byte of a packet |
| in_eop | input | 1 | The byte is the last byte of a packet |
| in_data | input | 8 | Packet byte |
| in_info | input | 8 | Information byte, sampled together with the end marker |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Read strobe; advances the head pointer when the address is the data register |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational from the address |
| full_irq | output | 1 | Full interrupt, high while any full status bit is set |

## Verification
The assertions assume a few things about the inputs. Each packet is framed by a start flag and a later end flag. The host does not write the control register and the current-slot register in the same cycle. The host uses the data register only while the current slot is valid. The stimulus meets these by sending whole packets, issuing host accesses one per cycle, and reading exactly the length reported for the current slot. Overflow is reached on purpose in two ways: by filling every slot, and by sending packets that are as long as the buffer or longer.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int NSLOT  = 8;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [3:0] {
    RA_CUR   = 4'd0,
    RA_VALID = 4'd1,
    RA_SEL   = 4'd2,
    RA_INFO  = 4'd3,
    RA_LEN   = 4'd4,
    RA_START = 4'd5,
    RA_HEAD  = 4'd6,
    RA_TAIL  = 4'd7,
    RA_FSTA  = 4'd8,
    RA_CTRL  = 4'd9,
    RA_DATA  = 4'd10
  } reg_addr_e;

  // first set bit of v, scanning upward from index 'from' with wrap-around
  function automatic slot_t oldest_slot(input logic [NSLOT-1:0] v, input slot_t from);
    slot_t r;
    slot_t k;
    logic  hit;
    r   = from;
    hit = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      k = slot_t'(int'(from) + i);
      if (!hit && v[k]) begin
        r   = k;
        hit = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rxb_wr_ctl.sv
module rxb_wr_ctl #(
  parameter  int ADDR_W = 6,
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic [PTR_W-1:0]  base,
  input  logic              slot_busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              commit,
  output logic [PTR_W-1:0]  commit_len,
  output logic [PTR_W-1:0]  ct_q,
  output logic              space_live,
  output logic              space_refused,
  output logic              slot_refused
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  logic [PTR_W-1:0] wp_q, wp_n, ct_n, wp_eff, used_eff, used;
  logic             busy_q, busy_n, drop_q, drop_n;
  logic             take, no_room, slot_block, accept, refused;

  always_comb begin
    wp_eff        = in_sop ? ct_q : wp_q;
    used_eff      = wp_eff - base;
    used          = wp_q - base;
    space_live    = (used == FULL_CNT);
    take          = in_valid && (in_sop || (busy_q && !drop_q));
    no_room       = (used_eff == FULL_CNT);
    slot_block    = slot_busy && (in_sop || in_eop);
    accept        = take && !no_room && !slot_block;
    refused       = take && !accept;
    space_refused = refused && no_room;
    slot_refused  = refused && !no_room;
    mem_we        = accept;
    mem_waddr     = wp_eff[ADDR_W-1:0];
    mem_wdata     = in_data;
    commit        = accept && in_eop;
    commit_len    = wp_eff + PTR_W'(1) - ct_q;
  end

  always_comb begin
    wp_n   = wp_q;
    ct_n   = ct_q;
    busy_n = busy_q;
    drop_n = drop_q;
    if (in_valid) begin
      if (in_sop) begin
        busy_n = 1'b1;
        drop_n = 1'b0;
      end
      if (accept) begin
        wp_n = wp_eff + PTR_W'(1);
      end else if (refused) begin
        wp_n   = ct_q;
        drop_n = 1'b1;
      end
      if (in_eop) begin
        busy_n = 1'b0;
        drop_n = 1'b0;
        if (commit) ct_n = wp_eff + PTR_W'(1);
        else        wp_n = ct_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      ct_q   <= '0;
      busy_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      ct_q   <= ct_n;
      busy_q <= busy_n;
      drop_q <= drop_n;
    end
  end

  a_r9_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
    used <= FULL_CNT);
  a_r7_drop_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && !commit) |=> (wp_q == ct_q));
  a_r3_tail_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ct_q));
endmodule

// File: rtl/rxb_desc_tbl.sv
module rxb_desc_tbl
  import rxb_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [PTR_W-1:0]            commit_start,
  input  logic [PTR_W-1:0]            commit_len,
  input  logic [7:0]                  commit_info,
  input  logic [NSLOT-1:0]            clr_mask,
  output logic [NSLOT-1:0]            valid_q,
  output logic [NSLOT-1:0]            valid_n,
  output slot_t                       wslot_q,
  output slot_t                       wslot_n,
  output logic [NSLOT-1:0][PTR_W-1:0] start_q,
  output logic [NSLOT-1:0][PTR_W-1:0] len_q,
  output logic [NSLOT-1:0][7:0]       info_q
);
  logic [NSLOT-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (commit) set_mask[wslot_q] = 1'b1;
    valid_n = (valid_q & ~clr_mask) | set_mask;
    wslot_n = commit ? slot_t'(wslot_q + slot_t'(1)) : wslot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wslot_q <= '0;
    end else begin
      valid_q <= valid_n;
      wslot_q <= wslot_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      info_q  <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (set_mask[i]) begin
          start_q[i] <= commit_start;
          len_q[i]   <= commit_len;
          info_q[i]  <= commit_info;
        end
      end
    end
  end

  a_r2_commit_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !valid_q[wslot_q]);
  a_r2_commit_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> valid_q[$past(wslot_q)]);
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (&clr_mask && !commit) |=> (valid_q == '0));
endmodule

// File: rtl/rxb_host_regs.sv
module rxb_host_regs
  import rxb_pkg::*;
#(
  parameter  int ADDR_W = 6,
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [3:0]                  host_addr,
  input  logic                        host_wr,
  input  logic                        host_rd,
  input  logic [7:0]                  host_wdata,
  output logic [7:0]                  host_rdata,
  input  logic [NSLOT-1:0]            valid_q,
  input  logic [NSLOT-1:0]            valid_n,
  input  slot_t                       wslot_n,
  input  logic [NSLOT-1:0][PTR_W-1:0] start_q,
  input  logic [NSLOT-1:0][PTR_W-1:0] len_q,
  input  logic [NSLOT-1:0][7:0]       info_q,
  input  logic [PTR_W-1:0]            ct_q,
  input  logic                        space_live,
  input  logic                        space_refused,
  input  logic                        slot_refused,
  input  logic [7:0]                  mem_rdata,
  output logic [NSLOT-1:0]            clr_mask,
  output logic [ADDR_W-1:0]           head_q,
  output logic                        full_irq
);
  slot_t             cur_q, cur_n, sel_q, sel_n, cur_sel, tgt;
  logic [ADDR_W-1:0] head_n, tgt_start, sel_start;
  logic [1:0]        fsta_q, fsta_n;
  logic              is_ctrl, clear_all, disc, cur_wr, sel_wr, auto_rd;

  always_comb begin
    is_ctrl   = host_wr && (host_addr == RA_CTRL);
    clear_all = is_ctrl && host_wdata[0];
    disc      = is_ctrl && host_wdata[1];
    cur_wr    = host_wr && (host_addr == RA_CUR);
    sel_wr    = host_wr && (host_addr == RA_SEL);
    auto_rd   = host_rd && (host_addr == RA_DATA);

    clr_mask = '0;
    if (clear_all)  clr_mask = '1;
    else if (disc)  clr_mask[cur_q] = 1'b1;

    cur_sel   = cur_wr ? host_wdata[SLOT_W-1:0] : cur_q;
    tgt       = oldest_slot(valid_n, wslot_n);
    // a slot committed this very cycle starts at the old committed tail
    tgt_start = valid_q[tgt]     ? start_q[tgt][ADDR_W-1:0]     : ct_q[ADDR_W-1:0];
    sel_start = valid_q[cur_sel] ? start_q[cur_sel][ADDR_W-1:0] : ct_q[ADDR_W-1:0];

    cur_n  = cur_sel;
    head_n = head_q;
    if (!valid_n[cur_sel]) begin
      if (|valid_n) begin
        cur_n  = tgt;
        head_n = tgt_start;
      end else begin
        head_n = ct_q[ADDR_W-1:0];
      end
    end else if (cur_wr) begin
      head_n = sel_start;
    end else if (auto_rd) begin
      head_n = head_q + ADDR_W'(1);
    end

    sel_n  = sel_wr ? host_wdata[SLOT_W-1:0] : sel_q;
    fsta_n = (clear_all || disc) ? 2'b00
           : (fsta_q | {(&valid_n) || slot_refused, space_live || space_refused});
    full_irq = |fsta_q;
  end

  always_comb begin
    case (host_addr)
      RA_CUR:   host_rdata = 8'(cur_q);
      RA_VALID: host_rdata = 8'(valid_q);
      RA_SEL:   host_rdata = 8'(sel_q);
      RA_INFO:  host_rdata = info_q[sel_q];
      RA_LEN:   host_rdata = 8'(len_q[sel_q]);
      RA_START: host_rdata = 8'(start_q[sel_q][ADDR_W-1:0]);
      RA_HEAD:  host_rdata = 8'(head_q);
      RA_TAIL:  host_rdata = 8'(ct_q[ADDR_W-1:0]);
      RA_FSTA:  host_rdata = 8'(fsta_q);
      RA_DATA:  host_rdata = mem_rdata;
      default:  host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      sel_q  <= '0;
      head_q <= '0;
      fsta_q <= '0;
    end else begin
      cur_q  <= cur_n;
      sel_q  <= sel_n;
      head_q <= head_n;
      fsta_q <= fsta_n;
    end
  end

  a_r5_discard_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (disc && valid_q[cur_q]) |=> !valid_q[$past(cur_q)]);
  a_r6_space_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (space_live && !clear_all && !disc) |=> fsta_q[0]);
  a_r6_slot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_refused && !clear_all && !disc) |=> fsta_q[1]);
  a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rd && !cur_wr && valid_n[cur_q]) |=> (head_q == $past(head_q) + ADDR_W'(1)));
endmodule

// File: rtl/rxb_pkt_store.sv
module rxb_pkt_store
  import rxb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  input  logic [7:0] in_info,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       full_irq
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]                  rsync_q;
  logic                        rst_int_n;
  logic [7:0]                  mem [DEPTH];
  logic                        mem_we;
  logic [ADDR_W-1:0]           mem_waddr, head_q;
  logic [7:0]                  mem_wdata, mem_rdata;
  logic                        commit, space_live, space_refused, slot_refused;
  logic [PTR_W-1:0]            commit_len, ct_q, base;
  logic [NSLOT-1:0]            valid_q, valid_n, clr_mask;
  slot_t                       wslot_q, wslot_n, oldest;
  logic [NSLOT-1:0][PTR_W-1:0] start_q, len_q;
  logic [NSLOT-1:0][7:0]       info_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end
  assign mem_rdata = mem[head_q];

  // space is held from the start of the oldest stored packet
  always_comb begin
    oldest = oldest_slot(valid_q, wslot_q);
    base   = (|valid_q) ? start_q[oldest] : ct_q;
  end

  rxb_wr_ctl #(.ADDR_W(ADDR_W)) i_wr (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .base(base), .slot_busy(valid_q[wslot_q]),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .commit(commit), .commit_len(commit_len), .ct_q(ct_q),
    .space_live(space_live), .space_refused(space_refused), .slot_refused(slot_refused)
  );

  rxb_desc_tbl #(.PTR_W(PTR_W)) i_tbl (
    .clk(clk), .rst_n(rst_int_n),
    .commit(commit), .commit_start(ct_q), .commit_len(commit_len), .commit_info(in_info),
    .clr_mask(clr_mask), .valid_q(valid_q), .valid_n(valid_n),
    .wslot_q(wslot_q), .wslot_n(wslot_n),
    .start_q(start_q), .len_q(len_q), .info_q(info_q)
  );

  rxb_host_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .valid_q(valid_q), .valid_n(valid_n), .wslot_n(wslot_n),
    .start_q(start_q), .len_q(len_q), .info_q(info_q), .ct_q(ct_q),
    .space_live(space_live), .space_refused(space_refused), .slot_refused(slot_refused),
    .mem_rdata(mem_rdata), .clr_mask(clr_mask), .head_q(head_q), .full_irq(full_irq)
  );
endmodule

// File: tb/test_rxb_pkt_store.sv
module test_rxb_pkt_store;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;

  logic       clk, rst_n;
  logic       in_valid, in_sop, in_eop;
  logic [7:0] in_data, in_info;
  logic [3:0] host_addr;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       full_irq;

  int         checks = 0;
  int         errors = 0;
  bit         done   = 0;
  logic [7:0] sbq[$];

  rxb_pkt_store #(.ADDR_W(ADDR_W)) i_rxb_pkt_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_info(in_info), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata), .full_irq(full_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b0; host_wr = 1'b0;
    #1 d = host_rdata;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    host_addr = a; host_wdata = v; host_wr = 1'b1;
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input int exp);
    logic [7:0] d;
    reg_rd(a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic chk_irq(input string req, input bit exp);
    @(negedge clk);
    #1 chk(req, int'(full_irq), int'(exp));
  endtask

  // driver: sends a packet and queues the bytes expected back
  task automatic send_pkt(input int len, input logic [7:0] info,
                          input logic [7:0] seed, input bit keep);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = seed + 8'(i);
      in_info  = info;
      if (keep) sbq.push_back(seed + 8'(i));
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  // monitor: auto-reads the current packet and compares with the queue
  task automatic read_cur(input string req);
    logic [7:0] c, n, d, e;
    reg_rd(4'd0, c);
    reg_wr(4'd2, c);
    reg_rd(4'd4, n);
    for (int i = 0; i < int'(n); i++) begin
      @(negedge clk);
      host_addr = 4'd10; host_rd = 1'b1;
      #1 d = host_rdata;
      if (sbq.size() == 0) begin
        chk({req, " queue empty"}, int'(d), -1);
      end else begin
        e = sbq.pop_front();
        chk(req, int'(d), int'(e));
      end
      @(posedge clk);
      #1 host_rd = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0; in_info = '0;
    host_addr = '0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk_reg("R1 cur", 4'd0, 0);
    chk_reg("R1 valid", 4'd1, 0);
    chk_reg("R1 head", 4'd6, 0);
    chk_reg("R1 tail", 4'd7, 0);
    chk_reg("R1 fsta", 4'd8, 0);
    chk_irq("R1 irq", 1'b0);

    send_pkt(5, 8'hA1, 8'd10, 1'b1);
    send_pkt(3, 8'hB2, 8'd40, 1'b1);
    chk_reg("R2 valid two", 4'd1, 8'h03);
    reg_wr(4'd2, 8'd0);
    chk_reg("R2 len0", 4'd4, 5);
    chk_reg("R2 start0", 4'd5, 0);
    chk_reg("R2 info0", 4'd3, 8'hA1);
    reg_wr(4'd2, 8'd1);
    chk_reg("R2 len1", 4'd4, 3);
    chk_reg("R3 start1 at old tail", 4'd5, 5);
    chk_reg("R2 info1", 4'd3, 8'hB2);
    chk_reg("R3 tail", 4'd7, 8);

    read_cur("R4 data pkt0");
    chk_reg("R4 head after read", 4'd6, 5);
    reg_wr(4'd9, 8'h02);
    chk_reg("R5 cur moves", 4'd0, 1);
    chk_reg("R5 head moves", 4'd6, 5);
    chk_reg("R5 valid", 4'd1, 8'h02);
    read_cur("R4 data pkt1");
    reg_wr(4'd9, 8'h02);
    chk_reg("R5 valid empty", 4'd1, 0);

    for (int k = 0; k < 8; k++) send_pkt(2, 8'(k), 8'(100 + 2 * k), 1'b1);
    chk_reg("R2 all slots valid", 4'd1, 8'hFF);
    chk_reg("R6 slot cause", 4'd8, 8'h02);
    chk_irq("R6 irq slots", 1'b1);
    send_pkt(2, 8'h99, 8'd90, 1'b0);
    chk_reg("R7 tail kept no slot", 4'd7, 24);
    chk_reg("R7 valid kept", 4'd1, 8'hFF);

    reg_wr(4'd9, 8'h01);
    sbq.delete();
    chk_reg("R8 clear all", 4'd1, 0);
    chk_reg("R6 fsta cleared", 4'd8, 0);
    chk_irq("R6 irq cleared", 1'b0);

    send_pkt(64, 8'h33, 8'd200, 1'b1);
    chk_reg("R9 full-size packet kept", 4'd1, 8'h04);
    chk_reg("R6 space cause", 4'd8, 8'h01);
    chk_irq("R6 irq space", 1'b1);
    send_pkt(4, 8'h44, 8'd7, 1'b0);
    chk_reg("R7 tail kept no space", 4'd7, 24);
    chk_reg("R7 valid kept space", 4'd1, 8'h04);
    chk_reg("R9 cur", 4'd0, 2);
    reg_wr(4'd2, 8'd2);
    chk_reg("R9 start", 4'd5, 24);
    chk_reg("R9 len", 4'd4, 64);
    read_cur("R9 wrapped data");
    chk_reg("R9 head wrapped", 4'd6, 24);
    reg_wr(4'd9, 8'h02);
    chk_reg("R5 valid after drop", 4'd1, 0);
    chk_reg("R6 fsta after drop", 4'd8, 0);

    send_pkt(70, 8'h55, 8'd1, 1'b0);
    chk_reg("R7 oversize valid", 4'd1, 0);
    chk_reg("R7 oversize tail", 4'd7, 24);
    chk_reg("R6 oversize cause", 4'd8, 8'h01);
    reg_wr(4'd9, 8'h01);
    chk_reg("R6 fsta clear", 4'd8, 0);

    send_pkt(1, 8'h5C, 8'd77, 1'b1);
    chk_reg("R2 single valid", 4'd1, 8'h08);
    chk_reg("R2 single cur", 4'd0, 3);
    reg_wr(4'd2, 8'd3);
    chk_reg("R2 single len", 4'd4, 1);
    chk_reg("R2 single info", 4'd3, 8'h5C);
    read_cur("R4 single data");
    reg_wr(4'd9, 8'h02);
    reg_wr(4'd0, 8'hFE);
    chk_reg("R10 cur write upper zero", 4'd0, 6);
    chk("R4 scoreboard drained", sbq.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule